// File: doc/BRIEF.md
# ADC output test pattern generator

This block sits on the path from a 12-bit converter sample input to the output data bus. Under register control it either forwards the live samples or substitutes a test pattern. Downstream capture logic can then be checked against known data. The patterns are fixed midscale and full-scale codes, a checkerboard, a word-wide one/zero toggle, and user-programmed words. A user word can be sent on every clock, or two user words can be interleaved.

Settings live in a small byte-wide register file. It has a write port with address, data and enable inputs, and a combinational read port. Together these stand in for a serial register interface. Samples are offset binary. The output is registered, so one clock of latency separates the input and the bus. Whenever the control byte changes, any two-word sequence restarts from its first word.

Top module: `adc_tpg_top`

## Requirements
- R1: While reset is held and after it is released, every register reads 00h and `smp_out` is 000h. The block therefore starts in pass-through.
- R2: With output test mode (control bits [3:0]) equal to 0, or to a reserved code (5, 6, 9 to 15), `smp_out` equals the value `smp_in` had at the previous rising clock edge.
- R3: Output test mode 1 gives 800h on every clock, mode 2 gives FFFh and mode 3 gives 000h.
- R4: Output test mode 4 (checkerboard) gives AAAh and 555h on alternating clocks.
- R5: Output test mode 7 (word toggle) gives FFFh and 000h on alternating clocks.
- R6: In output test mode 8 with user test mode (control bits [7:6]) equal to 00, 10 or 11, every output word is bits [15:4] of user pattern 1.
- R7: In output test mode 8 with user test mode 01, the output alternates between bits [15:4] of user pattern 1 and bits [15:4] of user pattern 2, pattern 1 first.
- R8: After any change of the control byte, the first output word of the new setting appears on the first clock after the write. A two-word sequence starts with its first word: AAAh for mode 4, FFFh for mode 7, pattern 1 for mode 8.
- R9: Registers are mapped as follows: control at C0h, user pattern 1 low byte at C2h, pattern 1 high byte at C3h, pattern 2 low byte at C4h and pattern 2 high byte at C5h. A write takes effect at the clock edge, and `rd_data` shows the addressed register combinationally.
- R10: Writes to C1h and to any address outside C0h to C5h change no register, and those addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data |
| smp_in | input | 12 | Live converter sample |
| smp_out | output | 12 | Output data word |

## Verification
The bench sweeps all 256 control byte values. After each write it checks four successive output words against values it computes from the mode fields. This separates the fixed codes from the two-word sequences, and it shows whether each sequence restarts on its first word. A varying sample stream is driven throughout, so pass-through, including every reserved code, can be told apart from the constant patterns by its one-clock delayed copy. Two different user pattern pairs distinguish the pattern 1 and pattern 2 words and show that the low nibble is dropped. A write to every address followed by a full readback checks the map, and shows that reserved addresses ignore writes and read as zero.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int AW = 8;
    localparam int RW = 8;
    localparam int DW = 12;

    typedef enum logic [3:0] {
        TM_OFF = 4'd0,
        TM_MID = 4'd1,
        TM_PFS = 4'd2,
        TM_NFS = 4'd3,
        TM_CHK = 4'd4,
        TM_TOG = 4'd7,
        TM_USR = 4'd8
    } tmode_e;

    localparam logic [1:0] UM_ALT = 2'b01;

    localparam logic [7:0] A_CTRL  = 8'hC0;
    localparam logic [7:0] A_P1_LO = 8'hC2;
    localparam logic [7:0] A_P1_HI = 8'hC3;
    localparam logic [7:0] A_P2_LO = 8'hC4;
    localparam logic [7:0] A_P2_HI = 8'hC5;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int REG_W  = RW,
    parameter int WORD_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  ctrl,
    output logic [WORD_W-1:0] usr1,
    output logic [WORD_W-1:0] usr2
);
    localparam int PW = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] p1_lo;
        logic [REG_W-1:0] p1_hi;
        logic [REG_W-1:0] p2_lo;
        logic [REG_W-1:0] p2_hi;
    } regs_t;

    regs_t r_d, r_q;
    logic [PW-1:0] pat1, pat2;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  r_d.ctrl  = wr_data;
                A_P1_LO: r_d.p1_lo = wr_data;
                A_P1_HI: r_d.p1_hi = wr_data;
                A_P2_LO: r_d.p2_lo = wr_data;
                A_P2_HI: r_d.p2_hi = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = r_q.ctrl;
            A_P1_LO: rd_data = r_q.p1_lo;
            A_P1_HI: rd_data = r_q.p1_hi;
            A_P2_LO: rd_data = r_q.p2_lo;
            A_P2_HI: rd_data = r_q.p2_hi;
            default: rd_data = '0;
        endcase
    end

    assign pat1 = {r_q.p1_hi, r_q.p1_lo};
    assign pat2 = {r_q.p2_hi, r_q.p2_lo};
    assign ctrl = r_q.ctrl;
    assign usr1 = pat1[PW-1 -: WORD_W];
    assign usr2 = pat2[PW-1 -: WORD_W];

    logic wr_rsv;
    assign wr_rsv = wr_en && !(wr_addr inside {A_CTRL, A_P1_LO, A_P1_HI, A_P2_LO, A_P2_HI});

    p_rsv_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rsv |=> $stable(r_q));
    p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> ctrl == $past(wr_data));
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
    import tpg_pkg::*;
#(
    parameter int WORD_W = DW,
    parameter int REG_W  = RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  ctrl,
    input  logic [WORD_W-1:0] usr1,
    input  logic [WORD_W-1:0] usr2,
    input  logic [WORD_W-1:0] smp_in,
    output logic [WORD_W-1:0] smp_out
);
    function automatic logic [WORD_W-1:0] alt_bits(input logic top);
        logic [WORD_W-1:0] v;
        for (int i = 0; i < WORD_W; i++) v[i] = (i % 2 == 1) ? top : ~top;
        return v;
    endfunction

    localparam logic [WORD_W-1:0] W_MID  = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] W_ONES = '1;
    localparam logic [WORD_W-1:0] W_ZERO = '0;
    localparam logic [WORD_W-1:0] CHK_A  = alt_bits(1'b1);
    localparam logic [WORD_W-1:0] CHK_B  = alt_bits(1'b0);

    typedef struct packed {
        logic [REG_W-1:0]  prev;
        logic              phase;
        logic [WORD_W-1:0] out;
    } st_t;

    st_t s_d, s_q;
    logic chg, ph;
    tmode_e mode;
    logic [1:0] umode;

    assign mode  = tmode_e'(ctrl[3:0]);
    assign umode = ctrl[7:6];

    always_comb begin
        chg       = (ctrl != s_q.prev);
        ph        = chg ? 1'b0 : s_q.phase;
        s_d.prev  = ctrl;
        s_d.phase = ~ph;
        case (mode)
            TM_MID:  s_d.out = W_MID;
            TM_PFS:  s_d.out = W_ONES;
            TM_NFS:  s_d.out = W_ZERO;
            TM_CHK:  s_d.out = ph ? CHK_B : CHK_A;
            TM_TOG:  s_d.out = ph ? W_ZERO : W_ONES;
            TM_USR:  s_d.out = (umode == UM_ALT && ph) ? usr2 : usr1;
            default: s_d.out = smp_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_out = s_q.out;

    logic pass_sel;
    assign pass_sel = !(ctrl[3:0] inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8});

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pass_sel |=> smp_out == $past(smp_in));
    p_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3:0] == 4'd1) |=> smp_out == W_MID);
    p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && (ctrl[3:0] == 4'd4 || ctrl[3:0] == 4'd7)) |=> smp_out == ~$past(smp_out));
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && ctrl[3:0] == 4'd7) |=> smp_out == W_ONES);
endmodule

// File: rtl/adc_tpg_top.sv
module adc_tpg_top
    import tpg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [RW-1:0] rd_data,
    input  logic [DW-1:0] smp_in,
    output logic [DW-1:0] smp_out
);
    logic [RW-1:0] ctrl;
    logic [DW-1:0] usr1, usr2;

    tpg_regs #(.ADDR_W(AW), .REG_W(RW), .WORD_W(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl(ctrl), .usr1(usr1), .usr2(usr2)
    );

    tpg_pattern #(.WORD_W(DW), .REG_W(RW)) u_pat (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .usr1(usr1), .usr2(usr2),
        .smp_in(smp_in), .smp_out(smp_out)
    );
endmodule

// File: tb/tb_adc_tpg_top.sv
`timescale 1ns/1ps
module tb_adc_tpg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0]  rd_data;
    logic [11:0] smp_in = '0;
    logic [11:0] smp_out;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    adc_tpg_top dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic string req_of(input logic [3:0] m, input logic [1:0] um);
        case (m)
            4'd1, 4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd7: return "R5";
            4'd8: return (um == 2'b01) ? "R7" : "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic int expw(input logic [7:0] c, input int k, input int vin,
                                input logic [15:0] p1, input logic [15:0] p2);
        case (c[3:0])
            4'd1: return 'h800;
            4'd2: return 'hFFF;
            4'd3: return 'h000;
            4'd4: return (k % 2 == 0) ? 'hAAA : 'h555;
            4'd7: return (k % 2 == 0) ? 'hFFF : 'h000;
            4'd8: return (c[7:6] == 2'b01 && k % 2 == 1) ? int'(p2 >> 4) : int'(p1 >> 4);
            default: return vin;
        endcase
    endfunction

    task automatic sweep(input logic [15:0] p1, input logic [15:0] p2);
        wr(8'hC2, p1[7:0]); wr(8'hC3, p1[15:8]);
        wr(8'hC4, p2[7:0]); wr(8'hC5, p2[15:8]);
        for (int i = 1; i <= 256; i++) begin
            logic [7:0] c;
            int v;
            c = 8'(i);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 8'hC0; wr_data = c;
            @(negedge clk);
            wr_en = 1'b0;
            v = (i * 37 + 5) & 'hFFF;
            smp_in = 12'(v);
            for (int k = 0; k < 4; k++) begin
                int nv;
                @(negedge clk);
                if (k == 0) chk($sformatf("R8 first word ctrl=%0h", c), smp_out, expw(c, k, v, p1, p2));
                else chk($sformatf("%s ctrl=%0h word=%0d", req_of(c[3:0], c[7:6]), c, k),
                         smp_out, expw(c, k, v, p1, p2));
                nv = (v * 5 + k + 11) & 'hFFF;
                v = nv;
                smp_in = 12'(v);
            end
        end
    endtask

    initial begin
        fork
            begin
                #1ms;
                bad++; total++;
                $display("FAIL watchdog expired");
            end
            begin
                repeat (3) @(negedge clk);
                smp_in = 12'h5A5;
                for (int a = 0; a < 256; a++) begin
                    rd_addr = 8'(a); #0.1;
                    if (a >= 'hC0 && a <= 'hC5) chk($sformatf("R1 reset reg %0h", a), rd_data, 0);
                end
                chk("R1 output in reset", smp_out, 0);
                rst_n = 1'b1;
                rd_addr = 8'hC0; #0.1;
                chk("R1 ctrl after reset", rd_data, 0);
                @(negedge clk);
                chk("R1 pass-through after reset", smp_out, 'h5A5);

                for (int a = 0; a < 256; a++) wr(8'(a), 8'(a ^ 8'h5C));
                for (int a = 0; a < 256; a++) begin
                    int e;
                    rd_addr = 8'(a); #0.1;
                    e = (a >= 'hC0 && a <= 'hC5 && a != 'hC1) ? (a ^ 'h5C) : 0;
                    chk($sformatf("%s readback %0h", (e == 0) ? "R10" : "R9", a), rd_data, e);
                end
                wr(8'hC0, 8'h00);

                sweep(16'hA5C3, 16'h3C7E);
                sweep(16'h0F0F, 16'hF0F1);

                wr(8'hC0, 8'h08);
                wr(8'hC7, 8'hFF);
                wr(8'hC1, 8'h48);
                @(negedge clk);
                chk("R10 reserved write no effect on output", smp_out, 'h0F0);
                rd_addr = 8'hC0; #0.1;
                chk("R10 ctrl unchanged", rd_data, 'h08);
                rd_addr = 8'hC1; #0.1;
                chk("R10 C1h reads zero", rd_data, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule